// File: doc/BRIEF.md
# Predicated ALU Execute Stage

This block is the execute stage of a small RISC core whose data-processing instructions are all one fixed 32-bit word. Each cycle it may accept one instruction together with the two source values the register file has already read. It splits the word into its fields and tests the 4-bit condition code against a stored N/Z/C/V flag register. If the test passes, it runs the ALU operation, which is one of ADD, SUB, MOV or CMP. It then reports a destination write and, if asked, updates the flags.

If the test fails, the instruction still takes its one cycle but has no effect. It makes no write and leaves the flags as they were. The stage holds no register file of its own. The write port it drives goes to a register file outside the block, and branches, memory access and register-specified shifts are handled elsewhere.

Top module: `pred_alu_stage`

## Requirements
- R1: While reset (`rst_n` low) is applied at a clock edge, the stage clears `wr_en`, `wr_idx`, `wr_data` and `flags_q` to zero.
- R2: The instruction word is read as follows. The condition is bits 31..28. The format is bits 27..26, and only 00 is executed. Immediate-select is bit 25, opcode is bits 24..21 and set-flags is bit 20. The first-source index is bits 19..16 and the destination index is bits 15..12. Operand2 is bits 11..0. A word with any other format retires with no write and no flag change.
- R3: The condition codes and the flags they test are listed here, with `flags_q` = {N,Z,C,V} in bits 3..0:
  - 0000: Z=1
  - 0001: Z=0
  - 0010: C=1
  - 0011: C=0
  - 0100: N=1
  - 0101: N=0
  - 0110: V=1
  - 0111: V=0
  - 1000: C=1 and Z=0
  - 1001: the complement of 1000
  - 1010: N==V
  - 1011: N!=V
  - 1100: Z=0 and N==V (signed greater)
  - 1101: the exact complement of 1100
- R4: When the condition fails, the instruction produces no write (`wr_en`=0) and leaves `flags_q` unchanged. It still uses its cycle.
- R5: Code 1110 executes whatever the flags hold. Code 1111 never executes.
- R6: ADD (opcode 0100) writes Rn+Op2 and SUB (opcode 0010) writes Rn−Op2 to the destination. They update the flags only when bit 20 is 1. In that case N is bit 31 of the result, Z is set when the result is zero, and V is signed overflow. C is the carry out for ADD and the not-borrow for SUB.
- R7: CMP (opcode 1010) never writes a register. It always sets N/Z/C/V from Rn−Op2, whatever bit 20 holds.
- R8: MOV (opcode 1101) writes Op2 to the destination. With bit 20 set it updates N and Z from the value and keeps C and V.
- R9: With bit 25 set, Op2 is bits 7..0 zero-extended to 32 bits and rotated right by twice the value in bits 11..8.
- R10: With bit 25 clear, Op2 is `rm_value`, unshifted.
- R11: A cycle with `instr_valid` low, or an instruction whose opcode is not one of the four above, produces no write and no flag change.
- R12: Results appear on the outputs one clock edge after the instruction is accepted. An instruction issued in the very next cycle sees the flags written by the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Data-processing instruction |
| rn_value | input | 32 | Value of the first-source register |
| rm_value | input | 32 | Value of the register named by bits 3..0 |
| wr_en | output | 1 | Destination write enable |
| wr_idx | output | 4 | Destination register index |
| wr_data | output | 32 | Value to write |
| flags_q | output | 4 | Current flags {N,Z,C,V} |

## Verification
Both the write outputs and the flag register are registered. An instruction sampled at one rising edge therefore shows its write and its flag update from that edge until the next one. The bench drives each instruction at a falling edge and removes it at the next falling edge, and it reads the outputs at that same falling edge, one register stage later. For back-to-back issue, the second instruction is driven while the first one's results are being checked. This shows that the flags set by the first instruction are the flags the second one tests.

// File: rtl/pred_alu_pkg.sv
// Package: shared field layout, opcode and condition encodings for the
// predicated ALU stage. Assumes the fixed 32-bit data-processing format.
package pred_alu_pkg;

    localparam int INSTR_W = 32;

    // Condition codes; the odd code of each pair is the complement of the even one.
    typedef enum logic [3:0] {
        C_EQ = 4'b0000, C_NE = 4'b0001, C_CS = 4'b0010, C_CC = 4'b0011,
        C_MI = 4'b0100, C_PL = 4'b0101, C_VS = 4'b0110, C_VC = 4'b0111,
        C_HI = 4'b1000, C_LS = 4'b1001, C_GE = 4'b1010, C_LT = 4'b1011,
        C_GT = 4'b1100, C_LE = 4'b1101, C_AL = 4'b1110, C_NV = 4'b1111
    } cond_e;

    localparam logic [3:0] OP_SUB = 4'b0010;
    localparam logic [3:0] OP_ADD = 4'b0100;
    localparam logic [3:0] OP_CMP = 4'b1010;
    localparam logic [3:0] OP_MOV = 4'b1101;

    // Instruction fields, most significant first.
    typedef struct packed {
        cond_e       cond;
        logic [1:0]  fmt;
        logic        imm_sel;
        logic [3:0]  opc;
        logic        set_fl;
        logic [3:0]  src_idx;
        logic [3:0]  dst_idx;
        logic [11:0] op2;
    } instr_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/pred_alu_decode.sv
// Module: splits the instruction word and forms the second operand.
// Assumes rm_value already holds the register named by bits 3..0.
module pred_alu_decode
    import pred_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [INSTR_W-1:0] instr_word,
    input  logic [DATA_W-1:0]  rm_value,
    output instr_t             fields,
    output logic               fmt_ok,
    output logic [DATA_W-1:0]  op2_value
);
    localparam int IMM_W = 8;
    localparam int ROT_W = 4;

    logic [ROT_W-1:0]    rot_amt;
    logic [DATA_W-1:0]   imm_ext;
    logic [2*DATA_W-1:0] imm_dbl;
    logic [2*DATA_W-1:0] imm_shift;

    // Field split and format check.
    always_comb begin
        fields = instr_t'(instr_word);
        fmt_ok = (fields.fmt == 2'b00);
    end

    // Rotated immediate or plain register operand.
    always_comb begin
        rot_amt   = fields.op2[IMM_W+ROT_W-1:IMM_W];
        imm_ext   = DATA_W'(fields.op2[IMM_W-1:0]);
        imm_dbl   = {imm_ext, imm_ext};
        imm_shift = imm_dbl >> {rot_amt, 1'b0};
        op2_value = fields.imm_sel ? imm_shift[DATA_W-1:0] : rm_value;
    end
endmodule

// File: rtl/pred_alu_cond.sv
// Module: evaluates a 4-bit condition code against the stored flags.
// Assumes the pairwise-complement encoding from the package.
module pred_alu_cond
    import pred_alu_pkg::*;
(
    input  cond_e  cond,
    input  flags_t flags,
    output logic   pass
);
    function automatic logic holds(input flags_t f, input logic [3:0] code);
        logic r;
        case (code)
            4'b0000: r = f.z;
            4'b0001: r = !f.z;
            4'b0010: r = f.c;
            4'b0011: r = !f.c;
            4'b0100: r = f.n;
            4'b0101: r = !f.n;
            4'b0110: r = f.v;
            4'b0111: r = !f.v;
            4'b1000: r = f.c && !f.z;
            4'b1001: r = !f.c || f.z;
            4'b1010: r = (f.n == f.v);
            4'b1011: r = (f.n != f.v);
            4'b1100: r = !f.z && (f.n == f.v);
            4'b1101: r = f.z || (f.n != f.v);
            4'b1110: r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    // Condition outcome.
    always_comb pass = holds(flags, cond);

    // R3/R5: each code and its pair partner always disagree (GT vs LE, AL vs never).
    always_comb begin
        a_r3_pair_complement: assert (holds(flags, cond) != holds(flags, cond ^ 4'b0001))
            else $error("condition pair not complementary");
    end
endmodule

// File: rtl/pred_alu_core.sv
// Module: combinational ADD/SUB/MOV/CMP with flag generation.
// Assumes operands are already selected; gives no write for unknown opcodes.
module pred_alu_core
    import pred_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        opc,
    input  logic              set_fl,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  flags_t            flags_in,
    output logic [DATA_W-1:0] result,
    output flags_t            flags_out,
    output logic              writes_rd,
    output logic              updates_fl,
    output logic              known_op
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] add_full;
    logic [DATA_W:0] sub_full;
    logic            add_ovf;
    logic            sub_ovf;

    // Adder and subtractor; SUB uses a + ~b + 1 so that carry = not-borrow.
    always_comb begin
        add_full = {1'b0, a} + {1'b0, b};
        sub_full = {1'b0, a} + {1'b0, ~b} + {{DATA_W{1'b0}}, 1'b1};
        add_ovf  = (a[MSB] == b[MSB]) && (add_full[MSB] != a[MSB]);
        sub_ovf  = (a[MSB] != b[MSB]) && (sub_full[MSB] != a[MSB]);
    end

    // Opcode select, write and flag policy.
    always_comb begin
        result     = '0;
        flags_out  = flags_in;
        writes_rd  = 1'b0;
        updates_fl = 1'b0;
        known_op   = 1'b1;
        case (opc)
            OP_ADD: begin
                result     = add_full[MSB:0];
                writes_rd  = 1'b1;
                updates_fl = set_fl;
                flags_out  = '{n: add_full[MSB], z: (add_full[MSB:0] == '0),
                               c: add_full[DATA_W], v: add_ovf};
            end
            OP_SUB, OP_CMP: begin
                result     = sub_full[MSB:0];
                writes_rd  = (opc == OP_SUB);
                updates_fl = (opc == OP_CMP) || set_fl;
                flags_out  = '{n: sub_full[MSB], z: (sub_full[MSB:0] == '0),
                               c: sub_full[DATA_W], v: sub_ovf};
            end
            OP_MOV: begin
                result     = b;
                writes_rd  = 1'b1;
                updates_fl = set_fl;
                flags_out  = '{n: b[MSB], z: (b == '0), c: flags_in.c, v: flags_in.v};
            end
            default: known_op = 1'b0;
        endcase
    end
endmodule

// File: rtl/pred_alu_stage.sv
// Module: top of the predicated execute stage. Holds the flag register
// and the registered write port. Assumes one instruction per cycle and
// register values read by the caller; synchronous active-low reset.
module pred_alu_stage
    import pred_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    input  logic [DATA_W-1:0] rn_value,
    input  logic [DATA_W-1:0] rm_value,
    output logic              wr_en,
    output logic [3:0]        wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic [3:0]        flags_q
);
    instr_t            fields;
    logic              fmt_ok;
    logic [DATA_W-1:0] op2_value;
    logic              cond_pass;
    logic [DATA_W-1:0] alu_result;
    flags_t            alu_flags;
    flags_t            cur_flags;
    logic              alu_writes;
    logic              alu_upd_fl;
    logic              alu_known;
    logic              fire;

    assign cur_flags = flags_t'(flags_q);

    pred_alu_decode #(.DATA_W(DATA_W)) u_decode (
        .instr_word (instr_word),
        .rm_value   (rm_value),
        .fields     (fields),
        .fmt_ok     (fmt_ok),
        .op2_value  (op2_value)
    );

    pred_alu_cond u_cond (
        .cond  (fields.cond),
        .flags (cur_flags),
        .pass  (cond_pass)
    );

    pred_alu_core #(.DATA_W(DATA_W)) u_core (
        .opc        (fields.opc),
        .set_fl     (fields.set_fl),
        .a          (rn_value),
        .b          (op2_value),
        .flags_in   (cur_flags),
        .result     (alu_result),
        .flags_out  (alu_flags),
        .writes_rd  (alu_writes),
        .updates_fl (alu_upd_fl),
        .known_op   (alu_known)
    );

    // Instruction takes effect only when valid, well-formed, known and condition true.
    always_comb fire = instr_valid && fmt_ok && alu_known && cond_pass;

    // Registered write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= fire && alu_writes;
            wr_idx  <= fields.dst_idx;
            wr_data <= alu_result;
        end
    end

    // Flag register update.
    always_ff @(posedge clk) begin
        if (!rst_n)                     flags_q <= '0;
        else if (fire && alu_upd_fl)    flags_q <= alu_flags;
    end

    // R4: a failed condition leaves no write and no flag change.
    a_r4_fail_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !cond_pass) |=> (!wr_en && $stable(flags_q)));

    // R11: idle cycles have no effect.
    a_r11_idle_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> (!wr_en && $stable(flags_q)));

    // R7: compare never writes a register.
    a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && fmt_ok && fields.opc == OP_CMP) |=> !wr_en);

    // R8: MOV keeps C and V.
    a_r8_mov_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && fmt_ok && fields.opc == OP_MOV) |=> (flags_q[1:0] == $past(flags_q[1:0])));

    // R5: always-code with a writing opcode always writes.
    a_r5_always_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && fmt_ok && fields.cond == C_AL && alu_known && fields.opc != OP_CMP) |=> wr_en);
endmodule

// File: tb/pred_alu_stage_tb_top.sv
`timescale 1ns/1ps
module pred_alu_stage_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic [31:0] rn_value = '0;
    logic [31:0] rm_value = '0;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data;
    logic [3:0]  flags_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pred_alu_stage dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .rn_value(rn_value), .rm_value(rm_value), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .flags_q(flags_q)
    );

    localparam logic [3:0] SUBo = 4'b0010, ADDo = 4'b0100, CMPo = 4'b1010, MOVo = 4'b1101;
    localparam logic [3:0] AL = 4'b1110;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] cnd, input logic i, input logic [3:0] op,
                                       input logic s, input logic [3:0] rn, input logic [3:0] rd,
                                       input logic [11:0] o2);
        return {cnd, 2'b00, i, op, s, rn, rd, o2};
    endfunction

    // Expected condition outcome from the R3/R5 table; f = {N,Z,C,V}.
    function automatic logic cond_ok(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            0: return z;            1: return !z;
            2: return cy;           3: return !cy;
            4: return n;            5: return !n;
            6: return v;            7: return !v;
            8: return cy && !z;     9: return !(cy && !z);
            10: return n == v;      11: return n != v;
            12: return !z && n == v; 13: return !(!z && n == v);
            14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Issue one instruction for one cycle; outputs are then readable.
    task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] m);
        @(negedge clk);
        instr_word = w; rn_value = a; rm_value = m; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "wr_en", 32'(wr_en), 0);
        chk("R1", "wr_idx", 32'(wr_idx), 0);
        chk("R1", "wr_data", wr_data, 0);
        chk("R1", "flags", 32'(flags_q), 0);
    endtask

    task automatic t_mov_imm();
        issue(mk(AL, 1, MOVo, 0, 0, 3, 12'h4FF), 0, 0);
        chk("R9", "ror8 wr_data", wr_data, 32'hFF000000);
        chk("R8", "wr_en", 32'(wr_en), 1);
        chk("R2", "wr_idx", 32'(wr_idx), 3);
        issue(mk(AL, 1, MOVo, 0, 0, 9, 12'h025), 0, 0);
        chk("R9", "ror0", wr_data, 32'h25);
        issue(mk(AL, 1, MOVo, 0, 0, 9, 12'h103), 0, 0);
        chk("R9", "ror2", wr_data, 32'hC0000000);
    endtask

    task automatic t_add();
        issue(mk(AL, 0, ADDo, 0, 5, 4, 12'h003), 7, 9);
        chk("R10", "add reg", wr_data, 16);
        chk("R6", "S=0 flags kept", 32'(flags_q), 0);
        issue(mk(AL, 0, ADDo, 1, 5, 4, 12'h003), 32'hFFFFFFFF, 1);
        chk("R6", "add wrap data", wr_data, 0);
        chk("R6", "add wrap flags ZC", 32'(flags_q), 4'b0110);
        issue(mk(AL, 0, ADDo, 1, 5, 4, 12'h003), 32'h7FFFFFFF, 1);
        chk("R6", "add ovf flags NV", 32'(flags_q), 4'b1001);
    endtask

    task automatic t_sub_mov_flags();
        issue(mk(AL, 1, SUBo, 1, 1, 2, 12'h003), 5, 0);
        chk("R6", "sub data", wr_data, 2);
        chk("R6", "sub flags C", 32'(flags_q), 4'b0010);
        issue(mk(AL, 1, SUBo, 1, 1, 2, 12'h005), 3, 0);
        chk("R6", "sub neg data", wr_data, 32'hFFFFFFFE);
        chk("R6", "sub borrow flags N", 32'(flags_q), 4'b1000);
        issue(mk(AL, 1, ADDo, 1, 1, 2, 12'h001), 32'h7FFFFFFF, 0);  // flags NV
        issue(mk(AL, 1, MOVo, 1, 0, 2, 12'h000), 0, 0);
        chk("R8", "mov S=1 sets Z keeps CV", 32'(flags_q), 4'b0101);
    endtask

    task automatic t_cond_table();
        logic [31:0] av [5] = '{32'd5, 32'd3, 32'd3, 32'h80000000, 32'h7FFFFFFF};
        logic [31:0] bv [5] = '{32'd3, 32'd3, 32'd5, 32'd1, 32'hFFFFFFFF};
        logic [3:0]  fv [5] = '{4'b0010, 4'b0110, 4'b1000, 4'b0011, 4'b1001};
        for (int k = 0; k < 5; k++) begin
            issue(mk(AL, 0, CMPo, 0, 1, 7, 12'h002), av[k], bv[k]);
            chk("R7", "cmp flags", 32'(flags_q), 32'(fv[k]));
            chk("R7", "cmp no write", 32'(wr_en), 0);
            for (int c = 0; c < 16; c++) begin
                issue(mk(4'(c), 1, ADDo, 1, 1, 6, 12'h001), 32'hFFFFFFFF, 0);
                chk(c >= 14 ? "R5" : "R3", $sformatf("cond %0d wr_en", c),
                    32'(wr_en), 32'(cond_ok(4'(c), fv[k])));
                if (cond_ok(4'(c), fv[k])) begin
                    chk("R6", "taken add flags ZC", 32'(flags_q), 4'b0110);
                    issue(mk(AL, 0, CMPo, 0, 1, 7, 12'h002), av[k], bv[k]);
                end else begin
                    chk("R4", "failed cond flags kept", 32'(flags_q), 32'(fv[k]));
                end
            end
        end
    endtask

    task automatic t_no_effect();
        issue(mk(AL, 0, CMPo, 0, 1, 7, 12'h002), 5, 3);  // flags 0010
        @(negedge clk);
        instr_word = mk(AL, 1, ADDo, 1, 1, 2, 12'h001); rn_value = 32'hFFFFFFFF; instr_valid = 1'b0;
        @(negedge clk);
        chk("R11", "invalid wr_en", 32'(wr_en), 0);
        chk("R11", "invalid flags", 32'(flags_q), 4'b0010);
        issue(mk(AL, 1, 4'b0000, 1, 1, 2, 12'h000), 0, 0);
        chk("R11", "unknown op wr_en", 32'(wr_en), 0);
        chk("R11", "unknown op flags", 32'(flags_q), 4'b0010);
        issue(mk(AL, 1, ADDo, 1, 1, 2, 12'h001) | 32'h0400_0000, 32'hFFFFFFFF, 0);
        chk("R2", "bad format wr_en", 32'(wr_en), 0);
        chk("R2", "bad format flags", 32'(flags_q), 4'b0010);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        instr_word = mk(AL, 0, CMPo, 0, 1, 0, 12'h002); rn_value = 3; rm_value = 5; instr_valid = 1'b1;
        @(negedge clk);
        chk("R12", "first cmp flags", 32'(flags_q), 4'b1000);
        instr_word = mk(4'b1100, 1, ADDo, 0, 1, 2, 12'h001); rn_value = 1;  // GT must fail
        @(negedge clk);
        chk("R12", "GT after lt wr_en", 32'(wr_en), 0);
        instr_word = mk(4'b1101, 1, ADDo, 0, 1, 2, 12'h001);                // LE must pass
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R12", "LE after lt wr_en", 32'(wr_en), 1);
        chk("R12", "LE data", wr_data, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_mov_imm();
        t_add();
        t_sub_mov_flags();
        t_cond_table();
        t_no_effect();
        t_back_to_back();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule